// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal pixel counter, the frame line counter and the four raster control outputs (horizontal sync, vertical sync, field and blanking) for interlaced 525-line and 625-line television rasters. A two-bit standard select picks the pixel count per line: rectangular-pixel 60 Hz, rectangular-pixel 50 Hz, or square-pixel 60 Hz. The counters advance only on cycles where the pixel clock enable is high.

As timing master the block free-runs and its sync outputs are meant to be driven off-chip. As slave it stays a flywheel, but the active edge of an external horizontal sync restarts the line and the active edge of an external vertical sync moves the line counter to the start of the next field. Each control output has its own polarity bit. The same polarity bits also set how the external syncs are read. The blanking window comes from register inputs: a horizontal start and end, a 9-bit vertical start split into a low byte and a high bit, and a vertical end. A lead option makes blanking drop one pixel before the first active pixel.

A hardware reset takes effect only after the reset input has been low for four consecutive clocks. A software reset request sets a busy bit that holds the counters in reset for four clocks and then clears by itself.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel counter `h_cnt` counts 0 to T-1 and then returns to 0, where T is H_TOT_M60 (858) for `std_sel` 2'b00 and 2'b11, H_TOT_50 (864) for 2'b01, and H_TOT_SQR (780) for 2'b10.
- R2: The line counter `line_cnt` advances by one each time `h_cnt` wraps and counts 0 to L-1, where L is LINES_50 (625) for `std_sel` 2'b01 and LINES_60 (525) for every other code.
- R3: The field level is 0 for lines below F1 = (L+1)/2 and 1 from F1 on, so it changes at the first line of each field. The field-relative line is `line_cnt` in field 0 and `line_cnt`-F1 in field 1.
- R4: The horizontal sync level is active while `h_cnt` < HS_WIDTH. The vertical sync level is active while the field-relative line is below VS_LINES. `sync_drive_en` is the inverse of `slave_mode`.
- R5: With a polarity bit at 1 the matching output is high when its level is active; with the bit at 0 it is low when active. `pol_hsync` and `pol_vsync` also define the active level of `ext_hsync` and `ext_vsync`.
- R6: With `blank_lead` = 0, horizontal blanking is active when `h_cnt` >= `hb_start` or `h_cnt` < `hb_end`.
- R7: With `blank_lead` = 1, the horizontal blanking test uses `h_cnt`+1, so blanking goes inactive one pixel before `h_cnt` reaches `hb_end`.
- R8: Vertical blanking is active when the field-relative line is >= {`vb_start_hi`,`vb_start_lo`} (9 bits) or below `vb_end`. The blank output is the OR of horizontal and vertical blanking.
- R9: In slave mode, on an enabled cycle where the external horizontal sync becomes active, `h_cnt` goes to 0 and the line counter advances.
- R10: In slave mode, on an enabled cycle where the external vertical sync becomes active, `line_cnt` loads F1 if the current field is 0 and 0 if it is 1.
- R11: Counters reset to 0 only on the fourth consecutive clock edge with `rst_n` low. Three low edges or fewer leave them counting.
- R12: A pulse on `sw_rst_req` sets `sw_reset_busy` after the next edge. The bit stays high for four clocks while the counters are held at 0, then clears by itself.
- R13: On cycles with `pix_en` low, `h_cnt` and `line_cnt` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, filtered over four clocks |
| pix_en | input | 1 | Pixel clock enable |
| sw_rst_req | input | 1 | Software reset request pulse |
| std_sel | input | 2 | Line standard select |
| slave_mode | input | 1 | 1 = lock to external syncs |
| ext_hsync | input | 1 | External horizontal sync |
| ext_vsync | input | 1 | External vertical sync |
| pol_hsync | input | 1 | Horizontal sync polarity (1 = active high) |
| pol_vsync | input | 1 | Vertical sync polarity |
| pol_field | input | 1 | Field output polarity |
| pol_blank | input | 1 | Blank output polarity |
| blank_lead | input | 1 | Blank ends one pixel early |
| hb_start | input | H_W | First blanked pixel of the line |
| hb_end | input | H_W | First active pixel of the line |
| vb_start_lo | input | 8 | Vertical blank start, low byte |
| vb_start_hi | input | 1 | Vertical blank start, bit 8 |
| vb_end | input | 9 | First active field-relative line |
| h_cnt | output | H_W | Pixel counter |
| line_cnt | output | V_W | Frame line counter |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| field_o | output | 1 | Field indicator |
| blank_o | output | 1 | Blanking |
| sync_drive_en | output | 1 | Sync outputs should be driven |
| sw_reset_busy | output | 1 | Software reset bit, self-clearing |

## Verification
On every cycle the assertions check that the pixel counter stays below the selected line total and wraps to zero. They also check that the counters hold while the enable is low, that master horizontal sync is active inside its width, that an external sync edge restarts the line in slave mode, and that the counters read zero when the software reset bit drops. Some behaviour can only be shown by the bench scenarios: the exact line and field sequence over whole frames, the blanking window with and without lead, the 9-bit vertical start, the polarity inversions, the slave vertical realignment, and the difference between a three-cycle and a four-cycle reset pulse.

// File: rtl/raster_timing_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the raster timing generator.
// Assumes std_sel codes are fixed by the brief; 2'b11 aliases 2'b00.
package raster_timing_pkg;

    typedef enum logic [1:0] {
        STD_M60_RECT   = 2'b00,
        STD_50_RECT    = 2'b01,
        STD_M60_SQR    = 2'b10,
        STD_M60_RECT_B = 2'b11
    } raster_std_e;

    // Control levels before polarity selection, in output order.
    typedef struct packed {
        logic blank;
        logic field;
        logic vs;
        logic hs;
    } ctl_lvl_t;

    // True when the selected standard uses the 50 Hz frame.
    function automatic logic std_is_50(input logic [1:0] sel);
        return sel == STD_50_RECT;
    endfunction

endpackage

// File: rtl/rtg_reset_ctl.sv
`timescale 1ns/1ps
// Reset control: filters the hardware reset so that it acts only after
// HW_RST_CYCLES consecutive low samples, and runs the self-clearing
// software reset bit that holds the core in reset for SW_RST_CYCLES clocks.
// Assumes rst_n is already synchronous to clk.
module rtg_reset_ctl #(
    parameter int HW_RST_CYCLES = 4,
    parameter int SW_RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst_req,
    output logic core_rst,
    output logic sw_busy
);
    localparam int SH_W  = HW_RST_CYCLES - 1;
    localparam int CNT_W = (SW_RST_CYCLES > 2) ? $clog2(SW_RST_CYCLES) : 1;

    logic [SH_W-1:0]  low_hist;
    logic [CNT_W-1:0] sw_cnt;
    logic             hw_rst;

    // Hardware reset fires when the current and all recorded samples are low.
    assign hw_rst   = !rst_n && (low_hist == '0);
    assign core_rst = hw_rst || sw_busy;

    // Record the most recent reset input samples.
    always_ff @(posedge clk) begin
        low_hist <= {low_hist[SH_W-2:0], rst_n};
    end

    // Software reset bit: set by request, cleared after its hold time.
    always_ff @(posedge clk) begin
        if (hw_rst) begin
            sw_busy <= 1'b0;
            sw_cnt  <= '0;
        end else if (sw_busy) begin
            if (sw_cnt == CNT_W'(SW_RST_CYCLES - 1)) begin
                sw_busy <= 1'b0;
                sw_cnt  <= '0;
            end else begin
                sw_cnt  <= sw_cnt + 1'b1;
            end
        end else if (sw_rst_req) begin
            sw_busy <= 1'b1;
        end
    end

endmodule

// File: rtl/rtg_edge_det.sv
`timescale 1ns/1ps
// Edge detector for one external sync input. Applies the polarity bit and
// flags the enabled cycle on which the input becomes active. The previous
// state resets to "active", so a sync held active through reset is not an edge.
module rtg_edge_det (
    input  logic clk,
    input  logic core_rst,
    input  logic pix_en,
    input  logic sync_in,
    input  logic pol,
    output logic edge_pulse
);
    logic act;
    logic prev_act;

    assign act        = pol ? sync_in : !sync_in;
    assign edge_pulse = pix_en && act && !prev_act;

    // Remember the active state seen on the last enabled cycle.
    always_ff @(posedge clk) begin
        if (core_rst)    prev_act <= 1'b1;
        else if (pix_en) prev_act <= act;
    end

endmodule

// File: rtl/rtg_hcount.sv
`timescale 1ns/1ps
// Horizontal counter: counts pixels up to the line total picked by the
// standard select. Wraps at the total, or restarts on a slave sync edge.
// Assumes every total fits in H_W bits.
module rtg_hcount
    import raster_timing_pkg::*;
#(
    parameter int H_W       = 10,
    parameter int H_TOT_M60 = 858,
    parameter int H_TOT_50  = 864,
    parameter int H_TOT_SQR = 780
) (
    input  logic           clk,
    input  logic           core_rst,
    input  logic           pix_en,
    input  logic [1:0]     std_sel,
    input  logic           hs_edge,
    output logic [H_W-1:0] h_cnt,
    output logic           line_adv
);
    logic [H_W-1:0] h_last;
    logic           h_wrap;

    // Last pixel index of the line for the selected standard.
    always_comb begin
        case (std_sel)
            STD_50_RECT: h_last = H_W'(H_TOT_50 - 1);
            STD_M60_SQR: h_last = H_W'(H_TOT_SQR - 1);
            default:     h_last = H_W'(H_TOT_M60 - 1);
        endcase
    end

    assign h_wrap   = h_cnt >= h_last;
    assign line_adv = pix_en && (h_wrap || hs_edge);

    // Pixel counter with wrap and slave restart.
    always_ff @(posedge clk) begin
        if (core_rst)      h_cnt <= '0;
        else if (line_adv) h_cnt <= '0;
        else if (pix_en)   h_cnt <= h_cnt + 1'b1;
    end

endmodule

// File: rtl/rtg_vcount.sv
`timescale 1ns/1ps
// Vertical counter: counts lines of an interlaced frame and derives the
// field level and the line index relative to the start of the field.
// A slave vertical sync edge moves to the start of the other field.
// Assumes both frame totals are odd and fit in V_W bits.
module rtg_vcount
    import raster_timing_pkg::*;
#(
    parameter int V_W      = 10,
    parameter int LINES_60 = 525,
    parameter int LINES_50 = 625
) (
    input  logic           clk,
    input  logic           core_rst,
    input  logic           pix_en,
    input  logic [1:0]     std_sel,
    input  logic           line_adv,
    input  logic           vs_edge,
    output logic [V_W-1:0] line_cnt,
    output logic           field_lvl,
    output logic [V_W-1:0] field_line
);
    localparam logic [V_W-1:0] F1_60   = V_W'((LINES_60 + 1) / 2);
    localparam logic [V_W-1:0] F1_50   = V_W'((LINES_50 + 1) / 2);
    localparam logic [V_W-1:0] LAST_60 = V_W'(LINES_60 - 1);
    localparam logic [V_W-1:0] LAST_50 = V_W'(LINES_50 - 1);

    logic [V_W-1:0] f1_line;
    logic [V_W-1:0] last_line;

    // Field-two start line and last frame line for the selected standard.
    assign f1_line   = std_is_50(std_sel) ? F1_50 : F1_60;
    assign last_line = std_is_50(std_sel) ? LAST_50 : LAST_60;

    assign field_lvl  = line_cnt >= f1_line;
    assign field_line = field_lvl ? (line_cnt - f1_line) : line_cnt;

    // Line counter: slave field alignment has priority over line advance.
    always_ff @(posedge clk) begin
        if (core_rst) begin
            line_cnt <= '0;
        end else if (pix_en && vs_edge) begin
            line_cnt <= field_lvl ? '0 : f1_line;
        end else if (line_adv) begin
            line_cnt <= (line_cnt >= last_line) ? '0 : line_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rtg_ctl_decode.sv
`timescale 1ns/1ps
// Control decode: turns the counters and blanking registers into the four
// control levels, then applies each output's polarity. Purely combinational;
// the outputs follow the counter registers with no added delay.
module rtg_ctl_decode
    import raster_timing_pkg::*;
#(
    parameter int H_W      = 10,
    parameter int V_W      = 10,
    parameter int HS_WIDTH = 64,
    parameter int VS_LINES = 3
) (
    input  logic [H_W-1:0] h_cnt,
    input  logic [V_W-1:0] field_line,
    input  logic           field_lvl,
    input  logic           blank_lead,
    input  logic [H_W-1:0] hb_start,
    input  logic [H_W-1:0] hb_end,
    input  logic [8:0]     vb_start,
    input  logic [8:0]     vb_end,
    input  logic [3:0]     pol,
    output logic [3:0]     ctl_out
);
    localparam int HP_W = H_W + 1;
    localparam int VC_W = (V_W > 9) ? V_W : 9;

    ctl_lvl_t        lvl;
    logic [HP_W-1:0] h_eval;
    logic [VC_W-1:0] fl_ext;
    logic            hblank;
    logic            vblank;

    assign h_eval = HP_W'(h_cnt) + HP_W'(blank_lead);
    assign fl_ext = VC_W'(field_line);

    // Blanking windows, horizontal with optional one-pixel lead.
    assign hblank = (h_eval >= HP_W'(hb_start)) || (h_eval < HP_W'(hb_end));
    assign vblank = (fl_ext >= VC_W'(vb_start)) || (fl_ext < VC_W'(vb_end));

    // Active levels before polarity.
    always_comb begin
        lvl.hs    = h_cnt < H_W'(HS_WIDTH);
        lvl.vs    = field_line < V_W'(VS_LINES);
        lvl.field = field_lvl;
        lvl.blank = hblank || vblank;
    end

    // Per-output polarity select.
    for (genvar i = 0; i < 4; i++) begin : g_pol
        assign ctl_out[i] = pol[i] ? lvl[i] : !lvl[i];
    end

endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
// Raster timing generator top. Connects reset control, external sync edge
// detection, horizontal and vertical counters and control decode.
// Assumes all register inputs are static while a field is running, and
// that rst_n and the external syncs are synchronous to clk.
module raster_timing_gen
    import raster_timing_pkg::*;
#(
    parameter int H_W       = 10,
    parameter int V_W       = 10,
    parameter int H_TOT_M60 = 858,
    parameter int H_TOT_50  = 864,
    parameter int H_TOT_SQR = 780,
    parameter int LINES_60  = 525,
    parameter int LINES_50  = 625,
    parameter int HS_WIDTH  = 64,
    parameter int VS_LINES  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pix_en,
    input  logic           sw_rst_req,
    input  logic [1:0]     std_sel,
    input  logic           slave_mode,
    input  logic           ext_hsync,
    input  logic           ext_vsync,
    input  logic           pol_hsync,
    input  logic           pol_vsync,
    input  logic           pol_field,
    input  logic           pol_blank,
    input  logic           blank_lead,
    input  logic [H_W-1:0] hb_start,
    input  logic [H_W-1:0] hb_end,
    input  logic [7:0]     vb_start_lo,
    input  logic           vb_start_hi,
    input  logic [8:0]     vb_end,
    output logic [H_W-1:0] h_cnt,
    output logic [V_W-1:0] line_cnt,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           field_o,
    output logic           blank_o,
    output logic           sync_drive_en,
    output logic           sw_reset_busy
);
    logic           core_rst;
    logic [1:0]     ext_sync;
    logic [1:0]     ext_pol;
    logic [1:0]     ext_edge;
    logic           hs_edge;
    logic           vs_edge;
    logic           line_adv;
    logic           field_lvl;
    logic [V_W-1:0] field_line;
    logic [3:0]     ctl_out;

    rtg_reset_ctl #(
        .HW_RST_CYCLES(4),
        .SW_RST_CYCLES(4)
    ) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst_req (sw_rst_req),
        .core_rst   (core_rst),
        .sw_busy    (sw_reset_busy)
    );

    assign ext_sync = {ext_vsync, ext_hsync};
    assign ext_pol  = {pol_vsync, pol_hsync};

    // One edge detector per external sync input.
    for (genvar s = 0; s < 2; s++) begin : g_ext
        rtg_edge_det u_edge (
            .clk        (clk),
            .core_rst   (core_rst),
            .pix_en     (pix_en),
            .sync_in    (ext_sync[s]),
            .pol        (ext_pol[s]),
            .edge_pulse (ext_edge[s])
        );
    end

    assign hs_edge       = slave_mode && ext_edge[0];
    assign vs_edge       = slave_mode && ext_edge[1];
    assign sync_drive_en = !slave_mode;

    rtg_hcount #(
        .H_W       (H_W),
        .H_TOT_M60 (H_TOT_M60),
        .H_TOT_50  (H_TOT_50),
        .H_TOT_SQR (H_TOT_SQR)
    ) u_h (
        .clk      (clk),
        .core_rst (core_rst),
        .pix_en   (pix_en),
        .std_sel  (std_sel),
        .hs_edge  (hs_edge),
        .h_cnt    (h_cnt),
        .line_adv (line_adv)
    );

    rtg_vcount #(
        .V_W      (V_W),
        .LINES_60 (LINES_60),
        .LINES_50 (LINES_50)
    ) u_v (
        .clk        (clk),
        .core_rst   (core_rst),
        .pix_en     (pix_en),
        .std_sel    (std_sel),
        .line_adv   (line_adv),
        .vs_edge    (vs_edge),
        .line_cnt   (line_cnt),
        .field_lvl  (field_lvl),
        .field_line (field_line)
    );

    rtg_ctl_decode #(
        .H_W      (H_W),
        .V_W      (V_W),
        .HS_WIDTH (HS_WIDTH),
        .VS_LINES (VS_LINES)
    ) u_dec (
        .h_cnt      (h_cnt),
        .field_line (field_line),
        .field_lvl  (field_lvl),
        .blank_lead (blank_lead),
        .hb_start   (hb_start),
        .hb_end     (hb_end),
        .vb_start   ({vb_start_hi, vb_start_lo}),
        .vb_end     (vb_end),
        .pol        ({pol_blank, pol_field, pol_vsync, pol_hsync}),
        .ctl_out    (ctl_out)
    );

    assign hsync_o = ctl_out[0];
    assign vsync_o = ctl_out[1];
    assign field_o = ctl_out[2];
    assign blank_o = ctl_out[3];

endmodule

// File: rtl/raster_timing_chk.sv
`timescale 1ns/1ps
// Checker for the raster timing generator, attached by bind. Watches ports
// only and keeps its own copy of the previous external sync state.
module raster_timing_chk #(
    parameter int H_W       = 10,
    parameter int V_W       = 10,
    parameter int H_TOT_M60 = 858,
    parameter int H_TOT_50  = 864,
    parameter int H_TOT_SQR = 780,
    parameter int HS_WIDTH  = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pix_en,
    input logic [1:0]     std_sel,
    input logic           slave_mode,
    input logic           ext_hsync,
    input logic           pol_hsync,
    input logic [H_W-1:0] h_cnt,
    input logic [V_W-1:0] line_cnt,
    input logic           hsync_o,
    input logic           sw_reset_busy
);
    logic [H_W-1:0] tot;
    logic           hs_act;
    logic           hs_prev;

    assign tot    = (std_sel == 2'b01) ? H_W'(H_TOT_50) :
                    (std_sel == 2'b10) ? H_W'(H_TOT_SQR) : H_W'(H_TOT_M60);
    assign hs_act = pol_hsync ? ext_hsync : !ext_hsync;

    // Track the external horizontal sync on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset_busy) hs_prev <= 1'b1;
        else if (pix_en)             hs_prev <= hs_act;
    end

    p_h_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        h_cnt < tot);

    p_h_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n || sw_reset_busy)
        (pix_en && !slave_mode && h_cnt == tot - 1'b1) |=> (h_cnt == '0));

    p_hsync_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && pol_hsync && h_cnt < H_W'(HS_WIDTH)) |-> hsync_o);

    p_slave_hreload_r9: assert property (@(posedge clk) disable iff (!rst_n || sw_reset_busy)
        (slave_mode && pix_en && hs_act && !hs_prev) |=> (h_cnt == '0));

    p_swrst_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_reset_busy) |-> (h_cnt == '0 && line_cnt == '0));

    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n || sw_reset_busy)
        !pix_en |=> ($stable(h_cnt) && $stable(line_cnt)));

endmodule

bind raster_timing_gen raster_timing_chk #(
    .H_W       (H_W),
    .V_W       (V_W),
    .H_TOT_M60 (H_TOT_M60),
    .H_TOT_50  (H_TOT_50),
    .H_TOT_SQR (H_TOT_SQR),
    .HS_WIDTH  (HS_WIDTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pix_en        (pix_en),
    .std_sel       (std_sel),
    .slave_mode    (slave_mode),
    .ext_hsync     (ext_hsync),
    .pol_hsync     (pol_hsync),
    .h_cnt         (h_cnt),
    .line_cnt      (line_cnt),
    .hsync_o       (hsync_o),
    .sw_reset_busy (sw_reset_busy)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
// Bench: small raster configuration, full-frame sweeps per standard with
// expected outputs computed arithmetically, plus slave and reset scenarios.
module raster_timing_gen_tb_top;
    localparam int H_W = 10;
    localparam int V_W = 10;
    localparam int T60 = 20;
    localparam int T50 = 24;
    localparam int TSQ = 16;
    localparam int L60 = 9;
    localparam int L50 = 11;
    localparam int HSW = 3;
    localparam int VSL = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pix_en = 1'b1;
    logic           sw_rst_req = 1'b0;
    logic [1:0]     std_sel = 2'b00;
    logic           slave_mode = 1'b0;
    logic           ext_hsync = 1'b0;
    logic           ext_vsync = 1'b0;
    logic           pol_hsync = 1'b1;
    logic           pol_vsync = 1'b1;
    logic           pol_field = 1'b1;
    logic           pol_blank = 1'b1;
    logic           blank_lead = 1'b0;
    logic [H_W-1:0] hb_start = '0;
    logic [H_W-1:0] hb_end = '0;
    logic [7:0]     vb_start_lo = 8'd4;
    logic           vb_start_hi = 1'b0;
    logic [8:0]     vb_end = 9'd1;
    logic [H_W-1:0] h_cnt;
    logic [V_W-1:0] line_cnt;
    logic           hsync_o, vsync_o, field_o, blank_o, sync_drive_en, sw_reset_busy;

    int  n_checks = 0;
    int  n_fail = 0;
    int  n = 0;
    bit  done = 1'b0;

    always #2.5 clk = !clk;

    raster_timing_gen #(
        .H_W(H_W), .V_W(V_W), .H_TOT_M60(T60), .H_TOT_50(T50), .H_TOT_SQR(TSQ),
        .LINES_60(L60), .LINES_50(L50), .HS_WIDTH(HSW), .VS_LINES(VSL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .sw_rst_req(sw_rst_req),
        .std_sel(std_sel), .slave_mode(slave_mode), .ext_hsync(ext_hsync),
        .ext_vsync(ext_vsync), .pol_hsync(pol_hsync), .pol_vsync(pol_vsync),
        .pol_field(pol_field), .pol_blank(pol_blank), .blank_lead(blank_lead),
        .hb_start(hb_start), .hb_end(hb_end), .vb_start_lo(vb_start_lo),
        .vb_start_hi(vb_start_hi), .vb_end(vb_end), .h_cnt(h_cnt),
        .line_cnt(line_cnt), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .field_o(field_o), .blank_o(blank_o), .sync_drive_en(sync_drive_en),
        .sw_reset_busy(sw_reset_busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // One clock with the given enable; inputs change and outputs are read 1 ns after the edge.
    task automatic tick(input bit pen);
        pix_en = pen;
        @(posedge clk);
        #1;
        if (pen) n++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) tick(1'b1);
        rst_n = 1'b1;
        n = 0;
    endtask

    function automatic int htot(input int s);
        return (s == 1) ? T50 : (s == 2) ? TSQ : T60;
    endfunction

    function automatic int ltot(input int s);
        return (s == 1) ? L50 : L60;
    endfunction

    function automatic int lvl(input bit pol, input bit act);
        return pol ? int'(act) : int'(!act);
    endfunction

    // Run cycles and compare every output with the arithmetic raster model.
    task automatic sweep(input int s, input int cycles, input bit gate, input string xtag);
        int t, l, f1, h, ln, fl, hp, prev_h;
        bit fld, hb, vb, pen;
        t  = htot(s);
        l  = ltot(s);
        f1 = (l + 1) / 2;
        hb_start = H_W'(t - 3);
        hb_end   = H_W'(2);
        for (int k = 0; k < cycles; k++) begin
            pen    = gate ? ((k % 3) != 1) : 1'b1;
            prev_h = int'(h_cnt);
            tick(pen);
            h   = n % t;
            ln  = (n / t) % l;
            fld = ln >= f1;
            fl  = fld ? ln - f1 : ln;
            hp  = h + (blank_lead ? 1 : 0);
            hb  = (hp >= int'(hb_start)) || (hp < int'(hb_end));
            vb  = (fl >= int'({vb_start_hi, vb_start_lo})) || (fl < int'(vb_end));
            if (!pen) check({"R13 hold ", xtag}, int'(h_cnt), prev_h);
            check({"R1 h_cnt ", xtag}, int'(h_cnt), h);
            check({"R2 line_cnt ", xtag}, int'(line_cnt), ln);
            check({"R3 field ", xtag}, int'(field_o), lvl(pol_field, fld));
            check({"R4 hsync ", xtag}, int'(hsync_o), lvl(pol_hsync, h < HSW));
            check({"R4 vsync ", xtag}, int'(vsync_o), lvl(pol_vsync, fl < VSL));
            check({"R6 blank ", xtag}, int'(blank_o), lvl(pol_blank, hb || vb));
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #1;
        do_reset();
        // Reset state: R11 counters zero, R4 master drive, R12 bit clear.
        check("R11 reset h_cnt", int'(h_cnt), 0);
        check("R11 reset line_cnt", int'(line_cnt), 0);
        check("R3 reset field", int'(field_o), 0);
        check("R4 drive enable in master", int'(sync_drive_en), 1);
        check("R12 busy clear after reset", int'(sw_reset_busy), 0);

        // R1 R2 R3 R4 R6 R8: two full frames on every standard code.
        for (int s = 0; s < 4; s++) begin
            std_sel = 2'(s);
            do_reset();
            sweep(s, 2 * htot(s) * ltot(s), 1'b0, "R1");
        end

        // R5 inverted polarities and R7 blank lead.
        std_sel = 2'b00;
        {pol_hsync, pol_vsync, pol_field, pol_blank} = 4'b0000;
        blank_lead = 1'b1;
        do_reset();
        sweep(0, htot(0) * ltot(0), 1'b0, "R5 R7");
        {pol_hsync, pol_vsync, pol_field, pol_blank} = 4'b1111;
        blank_lead = 1'b0;

        // R8: high start bit set pushes the vertical start past the field.
        std_sel = 2'b01;
        vb_start_hi = 1'b1;
        do_reset();
        sweep(1, htot(1) * ltot(1), 1'b0, "R8");
        vb_start_hi = 1'b0;

        // R13: gated enable.
        std_sel = 2'b10;
        do_reset();
        sweep(2, 3 * htot(2) * ltot(2) / 2, 1'b1, "R13");

        // R9 R10: slave alignment on the 60 Hz rectangular raster (F1 = 5).
        std_sel = 2'b00;
        do_reset();
        slave_mode = 1'b1;
        repeat (7) tick(1'b1);
        check("R4 drive enable in slave", int'(sync_drive_en), 0);
        check("R9 free run in slave", int'(h_cnt), 7);
        ext_hsync = 1'b1;
        tick(1'b1);
        check("R9 h reload", int'(h_cnt), 0);
        check("R9 line advance", int'(line_cnt), 1);
        ext_hsync = 1'b0;
        tick(1'b1);
        check("R9 count after reload", int'(h_cnt), 1);
        ext_vsync = 1'b1;
        tick(1'b1);
        check("R10 load field two", int'(line_cnt), 5);
        check("R10 field level", int'(field_o), 1);
        check("R10 h continues", int'(h_cnt), 2);
        ext_vsync = 1'b0;
        tick(1'b1);
        check("R10 no edge while held", int'(line_cnt), 5);
        ext_vsync = 1'b1;
        tick(1'b1);
        check("R10 load field one", int'(line_cnt), 0);
        check("R10 field back to 0", int'(field_o), 0);
        ext_vsync = 1'b0;
        slave_mode = 1'b0;

        // R11: three low edges ignored, four reset.
        do_reset();
        repeat (10) tick(1'b1);
        rst_n = 1'b0;
        repeat (3) tick(1'b1);
        rst_n = 1'b1;
        check("R11 short pulse ignored", int'(h_cnt), 13);
        repeat (4) tick(1'b1);
        rst_n = 1'b0;
        repeat (4) tick(1'b1);
        check("R11 four-cycle reset h", int'(h_cnt), 0);
        check("R11 four-cycle reset line", int'(line_cnt), 0);
        rst_n = 1'b1;
        n = 0;

        // R12: software reset bit.
        repeat (5) tick(1'b1);
        sw_rst_req = 1'b1;
        tick(1'b1);
        sw_rst_req = 1'b0;
        check("R12 busy set", int'(sw_reset_busy), 1);
        check("R12 count on request edge", int'(h_cnt), 6);
        repeat (3) tick(1'b1);
        check("R12 busy held", int'(sw_reset_busy), 1);
        check("R12 counters held", int'(h_cnt), 0);
        tick(1'b1);
        check("R12 busy self-clears", int'(sw_reset_busy), 0);
        check("R12 h zero at clear", int'(h_cnt), 0);
        tick(1'b1);
        check("R12 counting resumes", int'(h_cnt), 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule